// File: doc/BRIEF.md
# Paged Expanded RAM Access Controller

This block sits on the external-data-space path of an 8-bit controller core. It decides whether each access lands in a 768-byte on-chip RAM or has to go to the off-chip bus. Two access forms exist. A wide access carries a full 16-bit pointer. A paged access carries only an 8-bit register-indirect offset, and a 2-bit page register supplies the bits above it.

A system enable bit can send every access off-chip. On-chip reads return their data one clock after the strobe. Any access the RAM cannot serve raises a same-cycle "external bus needed" flag and presents the resolved 16-bit address. The timing of the off-chip bus itself belongs to another block.

The page register and the system register are written and read over a small register bus. Only the defined bits of each are stored. Every other bit reads as zero.

Top module: `xram_access_ctrl`

## Requirements
- R1: After reset the page register reads 0x00 (page 0) and the system register reads 0x02 (on-chip RAM enabled, enable at bit 1).
- R2: With the enable set, a wide access (acc_paged_i=0) to addresses 0x0000 through 0x02FF is served on-chip. A write stores the byte, and ext_req_o stays 0.
- R3: A wide access to any address of 0x0300 or above raises ext_req_o in the strobe cycle, with ext_addr_o equal to the access address, and returns no on-chip read data.
- R4: A paged access (acc_paged_i=1) with page code 0, 1 or 2 reaches on-chip byte page*256 + offset, where the offset is acc_addr_i[7:0]. The resolved address appears on ext_addr_o.
- R5: A paged access with page code 3 maps to no on-chip byte. It raises ext_req_o with ext_addr_o = 0x0300 + offset.
- R6: With the enable clear, every access raises ext_req_o. Writes then leave the on-chip contents unchanged, and this is visible once the enable is set again.
- R7: rd_valid_o pulses for exactly one cycle, in the cycle after an on-chip read strobe, with the addressed byte on rd_data_o. Writes and off-chip accesses never pulse it.
- R8: Register writes keep only bits 1:0 of the page register (cfg_sel_i=0) and bit 1 of the system register (cfg_sel_i=1). All other bits read back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe, one cycle per access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_paged_i | input | 1 | 1 = 8-bit paged access, 0 = 16-bit wide access |
| acc_addr_i | input | 16 | Access address (paged form uses bits 7:0) |
| acc_wdata_i | input | 8 | Write data |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 = page register, 1 = system register |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Readback of the selected register |
| ext_req_o | output | 1 | Access must be carried by the external bus |
| ext_addr_o | output | 16 | Resolved 16-bit address of the access |
| rd_valid_o | output | 1 | On-chip read data valid |
| rd_data_o | output | 8 | On-chip read data |

## Verification
The hardest case to reach is a write made while the RAM is disabled. Nothing at the ports reveals at once that the write was dropped. To expose it, the stimulus first fills all 768 bytes with an arithmetic pattern. It then clears the enable and issues wide and paged writes to bytes that are already filled. Finally it sets the enable again and reads those bytes back, expecting the original pattern.

The same filled image serves several other checks. A sweep over every offset of all three valid pages confirms the paged mapping. A final series of register writes uses values with extra bits set, so that dropping a bit or keeping a wrong one changes which page or route is taken.

// File: rtl/xram_pkg.sv
package xram_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OFFS_W = 8;

  typedef enum logic {
    ACC_WIDE  = 1'b0,
    ACC_PAGED = 1'b1
  } acc_kind_e;

  typedef enum logic {
    REG_PAGE = 1'b0,
    REG_SYS  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/xram_cfg_regs.sv
module xram_cfg_regs
  import xram_pkg::*;
#(
  parameter int unsigned PAGE_W = 2,
  parameter int unsigned EN_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PAGE_W-1:0] page_o,
  output logic              en_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - PAGE_W;

  reg_sel_e    sel;
  logic [PAGE_W-1:0] page_q;
  logic        en_q;
  logic        unused_wdata;

  assign sel          = reg_sel_e'(sel_i);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      en_q   <= 1'b1;
    end else if (we_i) begin
      if (sel == REG_PAGE) page_q <= wdata_i[PAGE_W-1:0];
      else                 en_q   <= wdata_i[EN_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel == REG_PAGE) rdata_o = {{PAD_W{1'b0}}, page_q};
    else                 rdata_o[EN_BIT] = en_q;
  end

  assign page_o = page_q;
  assign en_o   = en_q;
endmodule

// File: rtl/xram_addr_decode.sv
module xram_addr_decode
  import xram_pkg::*;
#(
  parameter int unsigned PAGE_W = 2,
  parameter int unsigned DEPTH  = 768
) (
  input  logic              valid_i,
  input  logic              paged_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              en_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic              hit_o,
  output logic              ext_req_o
);
  localparam int unsigned HI_W = ADDR_W - OFFS_W - PAGE_W;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);

  acc_kind_e kind;
  assign kind = acc_kind_e'(paged_i);

  // paged form: page code fills the bits just above the 8-bit offset
  always_comb begin
    if (kind == ACC_PAGED) eff_addr_o = {{HI_W{1'b0}}, page_i, addr_i[OFFS_W-1:0]};
    else                   eff_addr_o = addr_i;
  end

  assign hit_o     = en_i && (eff_addr_o < LIMIT);
  assign ext_req_o = valid_i && !hit_o;
endmodule

// File: rtl/xram_store.sv
module xram_store
  import xram_pkg::*;
#(
  parameter int unsigned DEPTH = 768,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= re_i;
      if (re_i) rd_data_o <= mem[idx_i];
    end
  end
endmodule

// File: rtl/xram_access_ctrl.sv
module xram_access_ctrl
  import xram_pkg::*;
#(
  parameter int unsigned PAGE_W = 2,
  parameter int unsigned DEPTH  = 768,
  parameter int unsigned EN_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic              acc_paged_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              ext_req_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [PAGE_W-1:0] cfg_page;
  logic              ram_en;
  logic              ram_hit;
  logic [ADDR_W-1:0] eff_addr;
  logic              unused_hi;

  assign unused_hi = ^eff_addr[ADDR_W-1:IDX_W];

  xram_cfg_regs #(.PAGE_W(PAGE_W), .EN_BIT(EN_BIT)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .page_o  (cfg_page),
    .en_o    (ram_en),
    .rdata_o (cfg_rdata_o)
  );

  xram_addr_decode #(.PAGE_W(PAGE_W), .DEPTH(DEPTH)) u_dec (
    .valid_i    (acc_valid_i),
    .paged_i    (acc_paged_i),
    .addr_i     (acc_addr_i),
    .page_i     (cfg_page),
    .en_i       (ram_en),
    .eff_addr_o (eff_addr),
    .hit_o      (ram_hit),
    .ext_req_o  (ext_req_o)
  );

  xram_store #(.DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (acc_valid_i && acc_write_i && ram_hit),
    .re_i       (acc_valid_i && !acc_write_i && ram_hit),
    .idx_i      (eff_addr[IDX_W-1:0]),
    .wdata_i    (acc_wdata_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  assign ext_addr_o = eff_addr;
endmodule

// File: rtl/xram_access_chk.sv
module xram_access_chk
  import xram_pkg::*;
#(
  parameter int unsigned PAGE_W = 2,
  parameter int unsigned DEPTH  = 768
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic              acc_paged_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic [PAGE_W-1:0] page_i,
  input logic              en_i,
  input logic [DATA_W-1:0] cfg_rdata_i,
  input logic              ext_req_i,
  input logic              rd_valid_i
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH);
  localparam logic [PAGE_W-1:0] PAGE_TOP = '1;

  logic on_read;
  assign on_read = acc_valid_i && !acc_write_i && !ext_req_i;

  a_r3_high_wide_goes_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !acc_paged_i && acc_addr_i >= LIMIT |-> ext_req_i);

  a_r4_low_page_stays_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_paged_i && en_i && page_i != PAGE_TOP |-> !ext_req_i);

  a_r5_top_page_goes_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_paged_i && page_i == PAGE_TOP |-> ext_req_i);

  a_r6_disabled_goes_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !en_i |-> ext_req_i);

  a_r7_read_gives_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_read |=> rd_valid_i);

  a_r7_no_stray_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_read |=> !rd_valid_i);

  a_r8_spare_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_i[DATA_W-1:PAGE_W] == '0);
endmodule

bind xram_access_ctrl xram_access_chk #(.PAGE_W(PAGE_W), .DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .acc_paged_i (acc_paged_i),
  .acc_addr_i  (acc_addr_i),
  .page_i      (cfg_page),
  .en_i        (ram_en),
  .cfg_rdata_i (cfg_rdata_o),
  .ext_req_i   (ext_req_o),
  .rd_valid_i  (rd_valid_o)
);

// File: tb/xram_access_ctrl_test.sv
`timescale 1ns/1ps
module xram_access_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0, acc_write_i = 1'b0, acc_paged_i = 1'b0;
  logic [15:0] acc_addr_i = '0;
  logic [7:0]  acc_wdata_i = '0;
  logic        cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic        ext_req_o;
  logic [15:0] ext_addr_o;
  logic        rd_valid_o;
  logic [7:0]  rd_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  xram_access_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i), .acc_paged_i(acc_paged_i),
    .acc_addr_i(acc_addr_i), .acc_wdata_i(acc_wdata_i),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .ext_req_o(ext_req_o), .ext_addr_o(ext_addr_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + (a >> 8) * 91 + 5) & 255);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(bit sel, logic [7:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic cfg_check(bit sel, logic [7:0] exp, string tag);
    @(negedge clk);
    cfg_sel_i = sel;
    #1;
    chk(cfg_rdata_o == exp, tag, 32'(cfg_rdata_o), 32'(exp));
  endtask

  task automatic access(bit wr, bit paged, logic [15:0] a, logic [7:0] wd,
                        bit exp_ext, logic [15:0] exp_ea, logic [7:0] exp_rd, string tag);
    bit exp_v;
    @(negedge clk);
    acc_valid_i = 1'b1; acc_write_i = wr; acc_paged_i = paged;
    acc_addr_i = a; acc_wdata_i = wd;
    #1;
    chk(ext_req_o == exp_ext, {tag, " ext_req"}, 32'(ext_req_o), 32'(exp_ext));
    chk(ext_addr_o == exp_ea, {tag, " ext_addr"}, 32'(ext_addr_o), 32'(exp_ea));
    @(posedge clk);
    @(negedge clk);
    acc_valid_i = 1'b0;
    exp_v = !wr && !exp_ext;
    chk(rd_valid_o == exp_v, {tag, " R7 rd_valid"}, 32'(rd_valid_o), 32'(exp_v));
    if (exp_v) chk(rd_data_o == exp_rd, {tag, " rd_data"}, 32'(rd_data_o), 32'(exp_rd));
    if (exp_v) begin
      @(negedge clk);
      chk(rd_valid_o == 1'b0, {tag, " R7 single pulse"}, 32'(rd_valid_o), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    cfg_check(1'b0, 8'h00, "R1 page reset");
    cfg_check(1'b1, 8'h02, "R1 sys reset");

    for (int a = 0; a < 768; a++)
      access(1'b1, 1'b0, 16'(a), pat(a), 1'b0, 16'(a), 8'h00, "R2 wide write");
    for (int a = 0; a < 768; a++)
      access(1'b0, 1'b0, 16'(a), 8'h00, 1'b0, 16'(a), pat(a), "R2 wide read");

    for (int p = 0; p < 3; p++) begin
      cfg_write(1'b0, 8'(p));
      for (int o = 0; o < 256; o++)
        access(1'b0, 1'b1, 16'(16'h5A00 | o), 8'h00, 1'b0, 16'(p * 256 + o),
               pat(p * 256 + o), "R4 paged read");
    end
    cfg_write(1'b0, 8'h01);
    access(1'b1, 1'b1, 16'h0033, 8'hC3, 1'b0, 16'h0133, 8'h00, "R4 paged write");
    access(1'b0, 1'b0, 16'h0133, 8'h00, 1'b0, 16'h0133, 8'hC3, "R4 paged write readback");

    cfg_write(1'b0, 8'h03);
    for (int o = 0; o < 256; o += 17) begin
      access(1'b0, 1'b1, 16'(o), 8'h00, 1'b1, 16'(16'h0300 + o), 8'h00, "R5 page3 read");
      access(1'b1, 1'b1, 16'(o), 8'h11, 1'b1, 16'(16'h0300 + o), 8'h00, "R5 page3 write");
    end

    access(1'b0, 1'b0, 16'h02FF, 8'h00, 1'b0, 16'h02FF, pat(767), "R2 top byte");
    access(1'b0, 1'b0, 16'h0300, 8'h00, 1'b1, 16'h0300, 8'h00, "R3 first out");
    access(1'b1, 1'b0, 16'h0301, 8'h77, 1'b1, 16'h0301, 8'h00, "R3 write out");
    access(1'b0, 1'b0, 16'h1234, 8'h00, 1'b1, 16'h1234, 8'h00, "R3 mid");
    access(1'b0, 1'b0, 16'hFFFF, 8'h00, 1'b1, 16'hFFFF, 8'h00, "R3 max");

    cfg_write(1'b1, 8'h00);
    cfg_check(1'b1, 8'h00, "R6 sys cleared");
    cfg_write(1'b0, 8'h00);
    access(1'b1, 1'b0, 16'h0010, ~pat(16), 1'b1, 16'h0010, 8'h00, "R6 wide write off");
    access(1'b1, 1'b1, 16'h0020, ~pat(32), 1'b1, 16'h0020, 8'h00, "R6 paged write off");
    access(1'b0, 1'b0, 16'h0005, 8'h00, 1'b1, 16'h0005, 8'h00, "R6 read off");
    cfg_write(1'b1, 8'h02);
    access(1'b0, 1'b0, 16'h0010, 8'h00, 1'b0, 16'h0010, pat(16), "R6 kept 0x10");
    access(1'b0, 1'b0, 16'h0020, 8'h00, 1'b0, 16'h0020, pat(32), "R6 kept 0x20");

    cfg_write(1'b0, 8'hFC);
    cfg_check(1'b0, 8'h00, "R8 page FC");
    access(1'b0, 1'b1, 16'h0005, 8'h00, 1'b0, 16'h0005, pat(5), "R8 page FC route");
    cfg_write(1'b0, 8'hFE);
    cfg_check(1'b0, 8'h02, "R8 page FE");
    access(1'b0, 1'b1, 16'h0007, 8'h00, 1'b0, 16'h0207, pat(519), "R8 page FE route");
    cfg_write(1'b1, 8'hFD);
    cfg_check(1'b1, 8'h00, "R8 sys FD");
    access(1'b0, 1'b0, 16'h0007, 8'h00, 1'b1, 16'h0007, 8'h00, "R8 sys FD route");
    cfg_write(1'b1, 8'hFF);
    cfg_check(1'b1, 8'h02, "R8 sys FF");
    access(1'b0, 1'b0, 16'h0008, 8'h00, 1'b0, 16'h0008, pat(8), "R8 sys FF route");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule